// File: doc/BRIEF.md
# Instruction Fetch Patch Trap Unit

The block sits beside a processor's instruction-fetch port and compares every valid fetch address against a bank of programmable trap addresses. Each entry has its own enable bit. When a valid fetch hits an enabled entry, the block raises a one-cycle bus-fault pulse. The fault handler can then redirect execution to corrected code that lives elsewhere.

A sticky status word records that a trap fired and which entry caused it. Software reads that word and then releases it through a separate write-one-to-clear register. All state is reached through a simple word-addressed register port. Writes are strobed. Reads are combinational from the current register address.

Top module: `fetch_trap_unit`

## Requirements
- R1: After a synchronous active-low reset, every trap address, every enable bit, the fault flag, the recorded index and `bus_fault` are zero.
- R2: Trap entry n is a full 32-bit compare address at register word offset 4*n (bytes 0x00 up to 0x74 for 30 entries). It is written and read back unchanged.
- R3: The enable word is at offset 0x78. Bit n enables entry n. Bits at or above the entry count (30 by default) are not stored and read as zero.
- R4: `bus_fault` is high for exactly the cycle after a clock edge at which `fetch_vld` was high and `fetch_addr` equalled an enabled entry. With `fetch_vld` low there is no fault. Back-to-back matching fetches give back-to-back fault cycles.
- R5: An entry whose enable bit is clear never causes a fault, whatever address it holds.
- R6: When several enabled entries match the same fetch, the lowest-numbered entry is the one recorded.
- R7: The status register at offset 0x7C reads with bit 0 as the fault flag and bits 5:1 as the matching entry index. All other bits read zero. The flag is set on the same edge that launches the fault pulse. Writes to 0x7C have no effect.
- R8: While the flag is set, later matches still pulse `bus_fault`, but the recorded index stays frozen.
- R9: Writing a 1 in bit 0 at offset 0xA8 clears the flag. Writing 0 there has no effect. If a clear and a match arrive on the same edge, the flag stays set and the new match's index is recorded. Offset 0xA8 and every unmapped offset read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 8 | Register byte address for both read and write |
| reg_wen | input | 1 | Write strobe, acts on the rising edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| fetch_addr | input | 32 | Instruction-fetch address |
| fetch_vld | input | 1 | Fetch address is valid this cycle |
| bus_fault | output | 1 | Registered one-cycle fault pulse |

## Verification
A fetch or a register write presented before edge k becomes visible after edge k:
- `bus_fault` and the status word change together, one cycle after the stimulus.
- Read data follows the address combinationally from the state held after that edge.

The bench drives inputs just after a falling edge. A behavioural model updates at the rising edge and is compared with both outputs at the following falling edge, so every expected value is due exactly one edge after its cause. Same-edge cases (a clear together with a match, a write together with a fetch) rely on the model using the pre-edge register contents, as the design does.

// File: rtl/ftrap_pkg.sv
// Package: shared constants and types for the fetch trap unit.
// Assumes a byte-addressed register port with 32-bit words.
package ftrap_pkg;
    localparam int REG_AW     = 8;
    localparam int DATA_W     = 32;
    localparam int STAT_IDX_W = 5;
    localparam logic [REG_AW-1:0] OFF_ENABLE = 8'h78;
    localparam logic [REG_AW-1:0] OFF_STATUS = 8'h7C;
    localparam logic [REG_AW-1:0] OFF_CLEAR  = 8'hA8;

    typedef struct packed {
        logic                  hit;
        logic [STAT_IDX_W-1:0] idx;
    } match_t;
endpackage

// File: rtl/ftrap_regbank.sv
// Module: storage for trap compare addresses and their enable bits.
// Assumes entry n lives at word n (byte 4n), below the enable word.
module ftrap_regbank
    import ftrap_pkg::*;
#(
    parameter int NUM_ENTRIES = 30,
    parameter int ADDR_W      = 32
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en,
    input  logic [REG_AW-1:0]                  wr_addr,
    input  logic [DATA_W-1:0]                  wr_data,
    output logic [NUM_ENTRIES-1:0][ADDR_W-1:0] trap_addr,
    output logic [NUM_ENTRIES-1:0]             trap_en
);
    localparam int WORD_W = REG_AW - 2;

    logic in_array;
    logic en_sel;

    // Decode whether the write targets the address array or the enable word.
    always_comb begin
        in_array = wr_en && (wr_addr < OFF_ENABLE);
        en_sel   = wr_en && (wr_addr == OFF_ENABLE);
    end

    for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_entry
        // Hold one compare address; updates only on its own word.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                trap_addr[i] <= '0;
            end else if (in_array && (wr_addr[REG_AW-1:2] == WORD_W'(i))) begin
                trap_addr[i] <= wr_data[ADDR_W-1:0];
            end
        end
    end

    // Hold the per-entry enable bits; unused upper bits are never stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trap_en <= '0;
        end else if (en_sel) begin
            trap_en <= wr_data[NUM_ENTRIES-1:0];
        end
    end
endmodule

// File: rtl/ftrap_matcher.sv
// Module: combinational compare of a fetch address against all enabled
// entries with a lowest-index-wins priority pick.
// Assumes NUM_ENTRIES fits in the 5-bit index field.
module ftrap_matcher
    import ftrap_pkg::*;
#(
    parameter int NUM_ENTRIES = 30,
    parameter int ADDR_W      = 32
) (
    input  logic [ADDR_W-1:0]                  fetch_addr,
    input  logic [NUM_ENTRIES-1:0][ADDR_W-1:0] trap_addr,
    input  logic [NUM_ENTRIES-1:0]             trap_en,
    output match_t                             match
);
    logic [NUM_ENTRIES-1:0] hit_vec;

    for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_cmp
        // One equality comparator per entry, gated by its enable.
        assign hit_vec[i] = trap_en[i] && (trap_addr[i] == fetch_addr);
    end

    // Scan from the top so the lowest hitting index is the one kept.
    always_comb begin
        match = '0;
        for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                match.hit = 1'b1;
                match.idx = STAT_IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/ftrap_status.sv
// Module: fault pulse register and sticky status (flag plus index).
// Assumes the clear strobe and the match are sampled on the same edge;
// a new match outranks a simultaneous clear.
module ftrap_status
    import ftrap_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  fetch_vld_i,
    input  match_t                match_i,
    input  logic                  clr_i,
    output logic                  flag_q,
    output logic [STAT_IDX_W-1:0] idx_q,
    output logic                  fault_q
);
    logic trap_now;

    // A trap fires when a valid fetch hits any enabled entry.
    assign trap_now = fetch_vld_i && match_i.hit;

    // Register the single-cycle fault pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) fault_q <= 1'b0;
        else        fault_q <= trap_now;
    end

    // Sticky flag; a match beats a same-edge clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        flag_q <= 1'b0;
        else if (trap_now) flag_q <= 1'b1;
        else if (clr_i)    flag_q <= 1'b0;
    end

    // Capture the index only when the flag is free or being released.
    always_ff @(posedge clk) begin
        if (!rst_n)                              idx_q <= '0;
        else if (trap_now && (!flag_q || clr_i)) idx_q <= match_i.idx;
    end

    p_fault_needs_fetch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fault_q |-> $past(fetch_vld_i));
    p_fault_sets_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fault_q |-> flag_q);
    p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr_i) |=> flag_q);
    p_index_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr_i) |=> $stable(idx_q));
    p_clear_drops_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && clr_i && !(fetch_vld_i && match_i.hit)) |=> !flag_q);
endmodule

// File: rtl/fetch_trap_unit.sv
// Module: top of the fetch trap unit. Decodes the register port, muxes
// read data and ties the bank, matcher and status together.
// Assumes NUM_ENTRIES <= 30 so the array ends below the enable word.
module fetch_trap_unit
    import ftrap_pkg::*;
#(
    parameter int NUM_ENTRIES = 30,
    parameter int ADDR_W      = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        reg_addr,
    input  logic              reg_wen,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              fetch_vld,
    output logic              bus_fault
);
    localparam int WORD_W = REG_AW - 2;

    logic [NUM_ENTRIES-1:0][ADDR_W-1:0] trap_addr;
    logic [NUM_ENTRIES-1:0]             trap_en;
    match_t                             match;
    logic                               clr;
    logic                               flag;
    logic [STAT_IDX_W-1:0]              idx;
    logic [WORD_W-1:0]                  rd_word;

    ftrap_regbank #(.NUM_ENTRIES(NUM_ENTRIES), .ADDR_W(ADDR_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wen), .wr_addr(reg_addr),
        .wr_data(reg_wdata), .trap_addr(trap_addr), .trap_en(trap_en));

    ftrap_matcher #(.NUM_ENTRIES(NUM_ENTRIES), .ADDR_W(ADDR_W)) u_match (
        .fetch_addr(fetch_addr), .trap_addr(trap_addr), .trap_en(trap_en),
        .match(match));

    // Write-one strobe on bit 0 of the clear register.
    assign clr = reg_wen && (reg_addr == OFF_CLEAR) && reg_wdata[0];

    ftrap_status u_stat (
        .clk(clk), .rst_n(rst_n), .fetch_vld_i(fetch_vld), .match_i(match),
        .clr_i(clr), .flag_q(flag), .idx_q(idx), .fault_q(bus_fault));

    assign rd_word = reg_addr[REG_AW-1:2];

    // Combinational read mux; unmapped and write-only offsets return zero.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr < OFF_ENABLE) begin
            if (int'(rd_word) < NUM_ENTRIES)
                reg_rdata[ADDR_W-1:0] = trap_addr[rd_word];
        end else if (reg_addr == OFF_ENABLE) begin
            reg_rdata[NUM_ENTRIES-1:0] = trap_en;
        end else if (reg_addr == OFF_STATUS) begin
            reg_rdata[STAT_IDX_W:0] = {idx, flag};
        end
    end

    if (NUM_ENTRIES < 32) begin : g_en_chk
        p_enable_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_addr == OFF_ENABLE) |-> (reg_rdata[31:NUM_ENTRIES] == '0));
    end
    p_clear_reads_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == OFF_CLEAR) |-> (reg_rdata == '0));
    p_status_upper_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == OFF_STATUS) |-> (reg_rdata[31:STAT_IDX_W+1] == '0));
endmodule

// File: tb/test_fetch_trap_unit.sv
module test_fetch_trap_unit;
    localparam int N = 30;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic        reg_wen = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] fetch_addr = '0;
    logic        fetch_vld = 1'b0;
    logic        bus_fault;

    int errors = 0;
    int checks = 0;
    string cur_req = "R1";

    always #10ns clk = ~clk;

    fetch_trap_unit i_fetch_trap_unit (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wen(reg_wen),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fetch_addr(fetch_addr),
        .fetch_vld(fetch_vld), .bus_fault(bus_fault));

    // Behavioural reference model.
    logic [31:0] m_trap [N];
    logic [N-1:0] m_en;
    bit m_flag, m_fault;
    int m_idx;

    always @(posedge clk) begin
        int hit;
        bit clr;
        if (!rst_n) begin
            foreach (m_trap[i]) m_trap[i] = '0;
            m_en = '0; m_flag = 0; m_fault = 0; m_idx = 0;
        end else begin
            hit = -1;
            if (fetch_vld)
                for (int i = 0; i < N; i++)
                    if (hit < 0 && m_en[i] && m_trap[i] == fetch_addr) hit = i;
            clr = reg_wen && reg_addr == 8'hA8 && reg_wdata[0];
            m_fault = (hit >= 0);
            if (hit >= 0) begin
                if (!m_flag || clr) m_idx = hit;
                m_flag = 1;
            end else if (clr) m_flag = 0;
            if (reg_wen) begin
                if (reg_addr < 8'h78 && (reg_addr >> 2) < N) m_trap[reg_addr >> 2] = reg_wdata;
                else if (reg_addr == 8'h78) m_en = reg_wdata[N-1:0];
            end
        end
    end

    function automatic logic [31:0] m_read(logic [7:0] a);
        if (a < 8'h78) return ((a >> 2) < N) ? m_trap[a >> 2] : 32'h0;
        if (a == 8'h78) return 32'(m_en);
        if (a == 8'h7C) return 32'((m_idx << 1) | int'(m_flag));
        return 32'h0;
    endfunction

    task automatic compare();
        logic [31:0] exp_rd;
        exp_rd = m_read(reg_addr);
        checks++;
        if (bus_fault !== m_fault) begin
            errors++;
            $display("FAIL %s bus_fault actual=%0b expected=%0b t=%0t", cur_req, bus_fault, m_fault, $time);
        end
        checks++;
        if (reg_rdata !== exp_rd) begin
            errors++;
            $display("FAIL %s rdata@%h actual=%h expected=%h t=%0t", cur_req, reg_addr, reg_rdata, exp_rd, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wen = 1'b1;
        step();
        reg_wen = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a);
        reg_addr = a;
        step();
    endtask

    task automatic fetch(input logic [31:0] a);
        fetch_addr = a; fetch_vld = 1'b1;
        step();
        fetch_vld = 1'b0;
    endtask

    function automatic logic [31:0] pat(int n);
        return 32'h0800_0000 + 32'(n * 16) ^ 32'h0000_A000;
    endfunction

    initial begin
        #2ms;
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] lfsr;
        // R1: reset state
        cur_req = "R1";
        @(negedge clk);
        step(); step();
        rst_n = 1'b1;
        for (int a = 0; a < 8'hB0; a += 4) rd(8'(a));

        // R2: fill and read back entries
        cur_req = "R2";
        for (int n = 0; n < N; n++) wr(8'(n * 4), pat(n));
        for (int n = 0; n < N; n++) rd(8'(n * 4));

        // R3: enable word, upper bits not stored
        cur_req = "R3";
        wr(8'h78, 32'hFFFF_FFFF);
        rd(8'h78);
        wr(8'h78, 32'h2000_0020);       // entries 5 and 29

        // R4: match on enabled entry, then no fetch_vld
        cur_req = "R4";
        reg_addr = 8'h7C;
        fetch(pat(5));
        step();
        fetch_addr = pat(5); step();    // fetch_vld low: no fault

        // R7: status write ignored, flag stays
        cur_req = "R7";
        wr(8'h7C, 32'h0);
        rd(8'h7C);

        // R5: disabled entry never faults
        cur_req = "R5";
        fetch(pat(6));
        fetch(pat(0));
        step();

        // R8: later match still pulses, index frozen (back-to-back R4 too)
        cur_req = "R8";
        reg_addr = 8'h7C;
        fetch(pat(29));
        fetch(pat(5));
        step();

        // R9: write 0 no effect, write 1 clears
        cur_req = "R9";
        wr(8'hA8, 32'h0);
        rd(8'h7C);
        wr(8'hA8, 32'h1);
        rd(8'h7C);
        rd(8'hA8);

        // R6: duplicate addresses, lowest wins
        cur_req = "R6";
        wr(8'h0C, 32'hDEAD_BEEC);
        wr(8'h44, 32'hDEAD_BEEC);
        wr(8'h78, 32'h0002_0008);       // entries 3 and 17
        reg_addr = 8'h7C;
        fetch(32'hDEAD_BEEC);
        wr(8'hA8, 32'h1);
        wr(8'h78, 32'h0002_0000);       // only 17
        reg_addr = 8'h7C;
        fetch(32'hDEAD_BEEC);
        step();

        // R9: clear and match on the same edge
        cur_req = "R9";
        wr(8'h78, 32'h2002_0000);
        fetch_addr = pat(29); fetch_vld = 1'b1;
        wr(8'hA8, 32'h1);
        fetch_vld = 1'b0;
        rd(8'h7C);

        // R4: pseudo-random fetch stream with periodic clears
        cur_req = "R4";
        wr(8'h78, 32'h1555_5555);
        lfsr = 32'hACE1_1234;
        for (int k = 0; k < 300; k++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            fetch_vld = lfsr[3];
            fetch_addr = lfsr[4] ? pat(int'(lfsr[12:8]) % N) : lfsr;
            reg_wen = (lfsr[17:15] == 3'b000);
            reg_addr = reg_wen ? 8'hA8 : 8'h7C;
            reg_wdata = {31'b0, lfsr[20]};
            step();
        end
        reg_wen = 1'b0; fetch_vld = 1'b0;
        step();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule